// File: doc/BRIEF.md
# Microinstruction Queueing Unit

This unit keeps a pipelined data path supplied with microinstructions. Each instruction's microcode sequence lies at consecutive addresses of a control store, so no microinstruction names its successor. The unit takes an entry address from an opcode decoder and copies words one per cycle into a small hardware queue. When it copies a word flagged as the end of a sequence, it takes the next entry address straight away, so sequences for successive instructions follow each other in the queue without a gap. A word flagged as a conditional microbranch stops the copying. The unit then waits for a resolve pulse that supplies the address to restart from.

On the output side, each advance pulse from the data path shifts a four-stage chain of per-stage microinstruction registers. The first register takes the head of the queue, or an all-zero no-op when the queue is empty. The end-of-sequence flag of every queued entry is also brought out, so that a fetch unit can see where instruction boundaries sit. The control store is outside the block and is read through a combinational address/data port. The decoder, the data path and the fetch unit are also outside the block.

Top module: `microseq_queue`

## Requirements
- R1: A microinstruction word is W bits wide. Bit W-1 is the end-of-sequence flag, bit W-2 is the conditional-branch flag, and the low W-2 bits are payload. After reset all four stage registers hold zero, the queue is empty, and no decoder address is taken while the decoder offers none.
- R2: Copying starts at the address taken from the decoder and pushes the words at consecutive control-store addresses into the queue in order, at most one per cycle.
- R3: When the copied word has the end-of-sequence flag set and the branch flag clear, the next word copied comes from the next decoder address. `decTake` is high in exactly the cycles in which an offered decoder address is consumed, and is never high while `decValid` is low.
- R4: After a word with the branch flag set has been copied, nothing more is copied until `resolveValid` arrives. Copying then resumes at `resolveAddr`, and every entry already in the queue is kept in order. The branch flag takes precedence over the end-of-sequence flag.
- R5: A `resolveValid` pulse that arrives while no branch is pending has no effect on the sequence of words delivered.
- R6: No word is copied while the queue holds DEPTH entries. No word is lost or repeated when copying resumes.
- R7: In a cycle with `advance` high, each stage register k (k = 1..3) takes the value of stage k-1. Stage 0 takes the queue head, which is removed from the queue, or all zeros when the queue is empty. Stage k is bits [k*W +: W] of `mirOut`.
- R8: While `advance` is low, the stage registers hold their values and nothing leaves the queue.
- R9: Bit i of `qFinal` is the end-of-sequence flag of the i-th queued entry counted from the head (bit 0 = head). Bits for positions beyond the current fill level are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decoder offers an entry address |
| decAddr | input | AW | Entry address of the next sequence |
| decTake | output | 1 | Offered decoder address is consumed at this edge |
| csAddr | output | AW | Control-store read address |
| csData | input | W | Control-store word at `csAddr` (combinational) |
| resolveValid | input | 1 | Pending microbranch is resolved |
| resolveAddr | input | AW | Address at which copying resumes |
| advance | input | 1 | Data path shifts the stage chain this cycle |
| mirOut | output | 4*W | Stage registers, stage k at bits [k*W +: W] |
| qFinal | output | DEPTH | End-of-sequence flags of queued entries, head at bit 0 |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Full queue while the data path is stalled.** The bench fills the queue with `advance` held low and then drains it. A unit that kept copying would overwrite or drop words, which shows up as a gap in the delivered stream or as a wrong `qFinal` pattern.
- **Back-to-back sequences.** The bench feeds sequences of various lengths, including one-word sequences. A unit that chained badly would insert extra words or skip the first word of the following sequence.
- **Conditional microbranch.** The bench resolves each branch only after the branch word has reached stage 0. A unit that did not stall would deliver words from past the branch.
- **Stray resolve pulses.** Resolve pulses sent while no branch is pending would redirect copying in a faulty unit and corrupt the stream.
- **Empty queue.** The bench checks that a drained queue feeds zero no-ops rather than stale words.

// File: rtl/mq_pkg.sv
package mq_pkg;

  // strobes from the sequencing control to the queue datapath
  typedef struct packed {
    logic push;   // write csData into the queue tail
    logic pop;    // remove the queue head into stage 0
    logic shift;  // move the stage register chain
  } qStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,  // waiting for a decoder entry address
    SEQ_COPY = 2'd1,  // copying consecutive words
    SEQ_WAIT = 2'd2   // stalled behind a conditional microbranch
  } seqState_t;

endpackage

// File: rtl/mq_ctrl.sv
module mq_ctrl
  import mq_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          decValid,
  input  logic [AW-1:0] decAddr,
  output logic          decTake,
  output logic [AW-1:0] csAddr,
  input  logic          csFinal,
  input  logic          csGoto,
  input  logic          resolveValid,
  input  logic [AW-1:0] resolveAddr,
  input  logic          advance,
  input  logic          qFull,
  input  logic          qEmpty,
  output qStrobe_t      strobe
);

  seqState_t     state, nextState;
  logic [AW-1:0] pc, nextPc;

  assign csAddr = pc;

  always_comb begin
    nextState    = state;
    nextPc       = pc;
    decTake      = 1'b0;
    strobe.push  = 1'b0;
    strobe.pop   = advance && !qEmpty;
    strobe.shift = advance;
    case (state)
      SEQ_IDLE: begin
        if (decValid) begin
          decTake   = 1'b1;
          nextPc    = decAddr;
          nextState = SEQ_COPY;
        end
      end
      SEQ_COPY: begin
        if (!qFull) begin
          strobe.push = 1'b1;
          if (csGoto) begin
            nextState = SEQ_WAIT;
          end else if (csFinal) begin
            if (decValid) begin
              decTake = 1'b1;
              nextPc  = decAddr;
            end else begin
              nextState = SEQ_IDLE;
            end
          end else begin
            nextPc = pc + AW'(1);
          end
        end
      end
      SEQ_WAIT: begin
        if (resolveValid) begin
          nextPc    = resolveAddr;
          nextState = SEQ_COPY;
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      pc    <= '0;
    end else begin
      state <= nextState;
      pc    <= nextPc;
    end
  end

endmodule

// File: rtl/mq_dp.sv
module mq_dp
  import mq_pkg::*;
#(
  parameter int W      = 18,
  parameter int DEPTH  = 8,
  parameter int STAGES = 4,
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  qStrobe_t            strobe,
  input  logic [W-1:0]        csData,
  output logic                qFull,
  output logic                qEmpty,
  output logic [CNTW-1:0]     qCount,
  output logic [STAGES*W-1:0] mirFlat,
  output logic [DEPTH-1:0]    qFinal
);

  localparam int PTRW = $clog2(DEPTH);
  localparam int IW   = PTRW + 1;

  logic [W-1:0]    store [DEPTH];
  logic [PTRW-1:0] rdPtr, wrPtr;
  logic [CNTW-1:0] count;
  logic [W-1:0]    mir [STAGES];

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign qFull  = (count == CNTW'(DEPTH));
  assign qEmpty = (count == '0);
  assign qCount = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (strobe.push) begin
        store[wrPtr] <= csData;
        wrPtr        <= bump(wrPtr);
      end
      if (strobe.pop) rdPtr <= bump(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // stage register chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) mir[k] <= '0;
    end else if (strobe.shift) begin
      mir[0] <= strobe.pop ? store[rdPtr] : '0;
      for (int k = 1; k < STAGES; k++) mir[k] <= mir[k-1];
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_flat
    assign mirFlat[k*W +: W] = mir[k];
  end

  // end-of-sequence flags, head first
  always_comb begin
    logic [IW-1:0] slot;
    for (int i = 0; i < DEPTH; i++) begin
      slot = {1'b0, rdPtr} + IW'(i);
      if (slot >= IW'(DEPTH)) slot = slot - IW'(DEPTH);
      qFinal[i] = (CNTW'(i) < count) ? store[slot[PTRW-1:0]][W-1] : 1'b0;
    end
  end

endmodule

// File: rtl/microseq_queue.sv
module microseq_queue
  import mq_pkg::*;
#(
  parameter int PW    = 16,
  parameter int AW    = 9,
  parameter int DEPTH = 8,
  localparam int W      = PW + 2,
  localparam int STAGES = 4,
  localparam int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                decValid,
  input  logic [AW-1:0]       decAddr,
  output logic                decTake,
  output logic [AW-1:0]       csAddr,
  input  logic [W-1:0]        csData,
  input  logic                resolveValid,
  input  logic [AW-1:0]       resolveAddr,
  input  logic                advance,
  output logic [STAGES*W-1:0] mirOut,
  output logic [DEPTH-1:0]    qFinal
);

  qStrobe_t        strobe;
  logic            qFull, qEmpty;
  logic [CNTW-1:0] qCount;

  mq_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .decValid     (decValid),
    .decAddr      (decAddr),
    .decTake      (decTake),
    .csAddr       (csAddr),
    .csFinal      (csData[W-1]),
    .csGoto       (csData[W-2]),
    .resolveValid (resolveValid),
    .resolveAddr  (resolveAddr),
    .advance      (advance),
    .qFull        (qFull),
    .qEmpty       (qEmpty),
    .strobe       (strobe)
  );

  mq_dp #(.W(W), .DEPTH(DEPTH), .STAGES(STAGES), .CNTW(CNTW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .csData  (csData),
    .qFull   (qFull),
    .qEmpty  (qEmpty),
    .qCount  (qCount),
    .mirFlat (mirOut),
    .qFinal  (qFinal)
  );

endmodule

// File: rtl/microseq_queue_chk.sv
module microseq_queue_chk #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            decValid,
  input logic            decTake,
  input logic            advance,
  input logic [4*W-1:0]  mirOut,
  input logic [CNTW-1:0] qCount
);

  assert_take_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decTake |-> decValid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qCount <= CNTW'(DEPTH));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(mirOut));

  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> mirOut[4*W-1:W] == $past(mirOut[3*W-1:0]));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && qCount == '0) |=> mirOut[W-1:0] == '0);

endmodule

bind microseq_queue microseq_queue_chk #(.W(W), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .decValid (decValid),
  .decTake  (decTake),
  .advance  (advance),
  .mirOut   (mirOut),
  .qCount   (qCount)
);

// File: tb/microseq_queue_test.sv
`timescale 1ns/1ps
module microseq_queue_test;

  localparam int PW = 16;
  localparam int AW = 9;
  localparam int DEPTH = 8;
  localparam int W = PW + 2;

  logic clk = 0;
  logic rst_n = 0;
  logic decValid, decTake;
  logic [AW-1:0] decAddr, csAddr, resolveAddr;
  logic [W-1:0] csData;
  logic resolveValid = 0, advance = 0;
  logic [4*W-1:0] mirOut;
  logic [DEPTH-1:0] qFinal;

  always #2 clk = ~clk;  // 250 MHz

  microseq_queue uut (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decAddr(decAddr),
    .decTake(decTake), .csAddr(csAddr), .csData(csData),
    .resolveValid(resolveValid), .resolveAddr(resolveAddr),
    .advance(advance), .mirOut(mirOut), .qFinal(qFinal)
  );

  int errors = 0, checks = 0, cycles = 0;

  // control store model: 16-word slots, sequence s has length 1+(7s mod 6);
  // sequences with s mod 5 == 3 end on a branch word
  function automatic logic [W-1:0] romGen(input int a);
    int s, k, len;
    logic [W-1:0] w;
    s = a / 16; k = a % 16; len = 1 + (s * 7) % 6;
    w[PW-1:0] = PW'(a + 1);
    if (k >= len) begin w[W-1] = 1'b1; w[W-2] = 1'b0; end
    else begin
      w[W-1] = (k == len - 1);
      w[W-2] = (k == len - 1) && (s % 5 == 3);
    end
    return w;
  endfunction

  assign csData = romGen(int'(csAddr));

  // decoder model
  int decList [64];
  int resList [64];
  int nDec = 0, decIdx = 0, resIdx = 0;
  logic decEnable = 0;
  assign decValid = decEnable && (decIdx < nDec);
  assign decAddr  = (decIdx < nDec) ? AW'(decList[decIdx]) : '0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) decIdx <= 0;
    else if (decTake) decIdx <= decIdx + 1;

  logic [W-1:0] expd [1024];
  int nExp = 0, obsIdx = 0;

  task automatic buildExp();
    int d = 0, r = 0, addr;
    logic [W-1:0] w;
    nExp = 0;
    if (nDec == 0) return;
    addr = decList[d]; d++;
    while (nExp < 1000) begin
      w = romGen(addr);
      expd[nExp] = w; nExp++;
      if (w[W-2]) begin addr = resList[r]; r++; end
      else if (w[W-1]) begin
        if (d < nDec) begin addr = decList[d]; d++; end
        else break;
      end else addr++;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 0; decEnable = 0; advance = 0; resolveValid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    obsIdx = 0; resIdx = 0;
  endtask

  task automatic runPhase(input int advPct, input int hold, input bit spurious,
                          input string tag);
    int cnt = 0, tail = 0;
    bit advPrev = 0, resPend = 0;
    logic [4*W-1:0] prevMir;
    logic [DEPTH-1:0] expF;
    prevMir = mirOut;
    decEnable = 1;
    while ((obsIdx < nExp || tail < 4) && cnt < 5000) begin
      @(negedge clk); cnt++;
      if (advPrev) begin
        if (mirOut[W-1:0] != '0) begin
          if (obsIdx < nExp)
            check(mirOut[W-1:0] == expd[obsIdx], tag, "R2 stream word",
                  128'(mirOut[W-1:0]), 128'(expd[obsIdx]));
          else
            check(0, tag, "R3 extra word", 128'(mirOut[W-1:0]), 0);
          if (mirOut[W-2]) resPend = 1;
          obsIdx++;
        end
        check(mirOut[4*W-1:W] == prevMir[3*W-1:0], "R7", "chain shift",
              128'(mirOut[4*W-1:W]), 128'(prevMir[3*W-1:0]));
      end else begin
        check(mirOut == prevMir, "R8", "chain hold", 128'(mirOut), 128'(prevMir));
      end
      if (obsIdx >= nExp) tail++;
      if (hold > 0 && cnt == hold) begin
        for (int i = 0; i < DEPTH; i++) expF[i] = expd[i][W-1];
        check(qFinal == expF, "R9 R6", "full queue final flags",
              128'(qFinal), 128'(expF));
      end
      prevMir = mirOut;
      resolveValid = 0;
      if (resPend) begin
        resolveValid = 1; resolveAddr = AW'(resList[resIdx]);
        resIdx++; resPend = 0;
      end else if (spurious && ($urandom % 4 == 0)) begin
        resolveValid = 1; resolveAddr = AW'(500);
      end
      advance = (cnt < hold) ? 1'b0 : (($urandom % 100) < advPct);
      advPrev = advance;
    end
    resolveValid = 0;
    check(obsIdx == nExp, tag, "R6 words delivered", 128'(obsIdx), 128'(nExp));
    advance = 1;
    repeat (6) @(negedge clk);
    check(mirOut == '0, "R7", "empty queue feeds zero no-ops", 128'(mirOut), 0);
    check(qFinal == '0, "R9", "drained flags zero", 128'(qFinal), 0);
    check(decTake == 1'b0, "R3", "no take when decoder empty", 128'(decTake), 0);
    advance = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=%0d expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s;
    void'($urandom(32'h5eed_1234));
    doReset();
    @(negedge clk);
    check(mirOut == '0, "R1", "reset stage registers", 128'(mirOut), 0);
    check(qFinal == '0, "R1", "reset queue empty", 128'(qFinal), 0);
    check(decTake == 1'b0, "R1", "no take without decoder", 128'(decTake), 0);

    // directed: fill while stalled, stray resolve pulses (R5, R6)
    decList[0] = 16; decList[1] = 32; decList[2] = 64; decList[3] = 80;
    decList[4] = 16; nDec = 5;
    buildExp();
    runPhase(60, 20, 1, "R5 R6");

    // random: mixed sequences and branches (R2, R3, R4)
    doReset();
    for (int i = 0; i < 40; i++) decList[i] = 16 * ($urandom % 30);
    for (int i = 0; i < 64; i++) begin
      do s = $urandom % 30; while (s % 5 == 3);
      resList[i] = 16 * s + ($urandom % (1 + (s * 7) % 6));
    end
    nDec = 40;
    buildExp();
    runPhase(70, 0, 0, "R2 R3 R4");

    // directed: back-to-back one-word sequences, branch at 48, full rate
    doReset();
    for (int i = 0; i < 12; i++) decList[i] = (i == 5) ? 48 : 0;
    resList[0] = 0;
    nDec = 12;
    buildExp();
    runPhase(100, 0, 0, "R3 R4");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule